// File: doc/BRIEF.md
# Power Mode Register with Transition Handshake

This block is an 8-bit control register on a simple single-cycle bus. Software uses it to choose the operating power mode. The mode field sits in the low three bits. Code 000 requests high-speed operation and code 010 requests middle-speed operation.

When a write is accepted, the new mode is stored and a busy flag is raised. A one-cycle request carrying the new mode is also sent to an external power controller. The busy flag stays set until that controller returns a one-cycle done pulse.

A write is dropped if any of the following holds:
- the write-protect unlock input is low;
- a transition is still pending;
- the core is in a sleep state or moving into or out of one;
- low-speed operation is active;
- flash program/erase is in progress;
- the data carries a prohibited mode code.

The stored mode is driven out on its own port for downstream logic. The block does not switch voltages or clocks itself.

Top module: `pwr_mode_reg`

## Requirements
- R1: The block uses a synchronous active-high reset. After reset the mode is 010 (middle speed) and the busy flag is 0. A read then returns 0x02 and no request is pending.
- R2: Only mode codes 000 (high speed) and 010 (middle speed) are legal. A write with any other code in bits 2..0 leaves the mode and the busy flag unchanged and sends no request.
- R3: An accepted write is a write to the register address with every lockout clear and a legal code. At the clock edge that samples it, the block stores the code and sets busy. In that same cycle it raises `pc_req` for exactly one cycle, with `pc_mode` equal to the new code.
- R4: While busy is 1, a `pc_done` pulse clears busy at the next clock edge.
- R5: While busy is 1, writes leave the mode unchanged and raise no request.
- R6: While `wp_unlock` is 0, writes have no effect.
- R7: While `sleep_lock` is 1 (sleep, deep sleep, or the path between either and normal operation), writes have no effect.
- R8: While `lowspd_on` is 1, writes have no effect.
- R9: While `flash_pe` is 1, writes have no effect.
- R10: `bus_rdata` is registered and shows, one cycle after the address is presented, the read word for that address:
  - bits 2..0 hold the stored mode;
  - bit 4 holds the busy flag;
  - bits 3 and 7..5 always read 0, and write data in those bits is ignored;
  - any other address reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wp_unlock | input | 1 | Write protection released when 1 |
| sleep_lock | input | 1 | Sleep entry, sleep, or sleep exit in progress |
| lowspd_on | input | 1 | Low-speed operation active |
| flash_pe | input | 1 | Flash program/erase in progress |
| pc_req | output | 1 | One-cycle transition request |
| pc_mode | output | 3 | Mode carried with the request |
| pc_done | input | 1 | Transition-complete pulse from the power controller |
| mode_out | output | 3 | Currently stored mode |
| busy_out | output | 1 | Transition busy flag |

## Verification
The assertions check the following on every cycle:
- the stored mode is always a legal code;
- a request lasts one cycle and always comes with busy set and a matching mode;
- busy holds the mode steady until done arrives, and done clears it;
- no lockout input lets the mode move or a request fire;
- the reserved read bits stay zero.

Only the bench's scenarios can show the rest:
- the exact number of busy cycles for a given controller delay;
- that each rejected write truly leaves the read word unchanged;
- the read layout after a write whose reserved bits are set;
- the behaviour of a wrong address.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_HIGH = 3'b000,
    PM_MID  = 3'b010
  } pwr_mode_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m == PM_HIGH) || (m == PM_MID);
  endfunction
endpackage

// File: rtl/pmr_wr_gate.sv
module pmr_wr_gate
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_ADDR  = 8'hA0,
  parameter int NUM_LOCKS = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic [MODE_W-1:0]    wmode,
  input  logic                 unlock,
  input  logic [NUM_LOCKS-1:0] locks,
  input  logic                 busy,
  output logic                 accept
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic any_lock;
  logic hit;

  always_comb begin
    any_lock = 1'b0;
    for (int i = 0; i < NUM_LOCKS; i++) begin
      any_lock = any_lock | locks[i];
    end
    hit    = wr && (addr == MY_ADDR);
    accept = hit && unlock && !busy && !any_lock && mode_legal(wmode);
  end
endmodule

// File: rtl/pmr_state.sv
module pmr_state
  import pwr_mode_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = PM_MID
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [MODE_W-1:0] new_mode,
  input  logic              done,
  output logic [MODE_W-1:0] mode_q,
  output logic              busy_q,
  output logic              req_q,
  output logic [MODE_W-1:0] req_mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= RESET_MODE;
      busy_q     <= 1'b0;
      req_q      <= 1'b0;
      req_mode_q <= RESET_MODE;
    end else begin
      req_q <= accept;
      if (accept) begin
        mode_q     <= new_mode;
        req_mode_q <= new_mode;
        busy_q     <= 1'b1;
      end else if (busy_q && done) begin
        busy_q <= 1'b0;
      end
    end
  end

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
    mode_legal(mode_q));
  p_req_busy_r3: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (busy_q && req_mode_q == mode_q));
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);
  p_busy_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> req_q);
  p_done_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && done) |=> !busy_q);
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> (busy_q && $stable(mode_q) && !req_q));
endmodule

// File: rtl/pmr_rd.sv
module pmr_rd
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 8'hA0,
  parameter int BUSY_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MODE_W-1:0] mode,
  input  logic              busy,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);
  localparam logic [DATA_W-1:0] KEEP    =
    DATA_W'((1 << MODE_W) - 1) | DATA_W'(1 << BUSY_BIT);

  logic [DATA_W-1:0] word;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < MODE_W) begin : g_mode
      assign word[b] = mode[b];
    end else if (b == BUSY_BIT) begin : g_busy
      assign word[b] = busy;
    end else begin : g_rsvd
      assign word[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= (addr == MY_ADDR) ? word : '0;
  end

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~KEEP) == '0);
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (addr != MY_ADDR) |=> (rdata == '0));
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 8'hA0,
  parameter int BUSY_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wp_unlock,
  input  logic              sleep_lock,
  input  logic              lowspd_on,
  input  logic              flash_pe,
  output logic              pc_req,
  output logic [MODE_W-1:0] pc_mode,
  input  logic              pc_done,
  output logic [MODE_W-1:0] mode_out,
  output logic              busy_out
);
  localparam int NUM_LOCKS = 3;

  logic                 accept;
  logic [NUM_LOCKS-1:0] locks;

  assign locks = {flash_pe, lowspd_on, sleep_lock};

  pmr_wr_gate #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .NUM_LOCKS(NUM_LOCKS)
  ) u_gate (
    .addr(bus_addr), .wr(bus_wr), .wmode(bus_wdata[MODE_W-1:0]),
    .unlock(wp_unlock), .locks(locks), .busy(busy_out), .accept(accept)
  );

  pmr_state #(.RESET_MODE(PM_MID)) u_state (
    .clk(clk), .rst(rst), .accept(accept),
    .new_mode(bus_wdata[MODE_W-1:0]), .done(pc_done),
    .mode_q(mode_out), .busy_q(busy_out),
    .req_q(pc_req), .req_mode_q(pc_mode)
  );

  pmr_rd #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .BUSY_BIT(BUSY_BIT)
  ) u_rd (
    .clk(clk), .rst(rst), .addr(bus_addr),
    .mode(mode_out), .busy(busy_out), .rdata(bus_rdata)
  );

  p_wp_lock_r6: assert property (@(posedge clk) disable iff (rst)
    !wp_unlock |=> (!pc_req && $stable(mode_out)));
  p_sleep_lock_r7: assert property (@(posedge clk) disable iff (rst)
    sleep_lock |=> (!pc_req && $stable(mode_out)));
  p_lowspd_lock_r8: assert property (@(posedge clk) disable iff (rst)
    lowspd_on |=> (!pc_req && $stable(mode_out)));
  p_flash_lock_r9: assert property (@(posedge clk) disable iff (rst)
    flash_pe |=> (!pc_req && $stable(mode_out)));
endmodule

// File: tb/pwr_mode_reg_tb.sv
module pwr_mode_reg_tb;
  localparam logic [7:0] RA = 8'hA0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = RA;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wp_unlock = 1'b0, sleep_lock = 1'b0, lowspd_on = 1'b0, flash_pe = 1'b0;
  logic       pc_req;
  logic [2:0] pc_mode;
  logic       pc_done = 1'b0;
  logic [2:0] mode_out;
  logic       busy_out;

  int checks = 0;
  int errors = 0;
  int ctl_delay = 1;
  logic [2:0] exp_mode = 3'b010;
  bit finished = 0;

  always #10 clk = ~clk;

  pwr_mode_reg u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_unlock(wp_unlock),
    .sleep_lock(sleep_lock), .lowspd_on(lowspd_on), .flash_pe(flash_pe),
    .pc_req(pc_req), .pc_mode(pc_mode), .pc_done(pc_done),
    .mode_out(mode_out), .busy_out(busy_out)
  );

  function automatic bit legal(input logic [2:0] m);
    return (m == 3'b000) || (m == 3'b010);
  endfunction

  function automatic logic [7:0] rd_word(input logic [2:0] m, input logic b);
    return {3'b000, b, 1'b0, m};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // power controller model: done pulse ctl_delay cycles after the request
  initial begin
    forever begin
      @(negedge clk);
      if (pc_req) begin
        chk("R3 pc_mode", pc_mode, exp_mode);
        repeat (ctl_delay - 1) @(negedge clk);
        pc_done = 1'b1;
        @(negedge clk);
        pc_done = 1'b0;
      end
    end
  end

  // single write cycle; returns at the negedge after the sampling edge
  task automatic wr_cycle(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = RA;
  endtask

  // accepted-write follow-up: check busy window while hammering writes
  task automatic busy_window(input int d);
    for (int i = 1; i <= d; i++) begin
      bus_wdata = ($urandom_range(0, 1) != 0) ? 8'h00 : 8'h02;
      bus_wr = 1'b1;
      @(negedge clk);
      chk((i < d) ? "R5 busy held" : "R4 busy cleared", busy_out, (i < d));
      chk("R5 mode stable while busy", mode_out, exp_mode);
      chk("R5 no request while busy", pc_req, 0);
    end
    bus_wr = 1'b0;
    @(negedge clk);
    chk("R10 read after transition", bus_rdata, rd_word(exp_mode, 1'b0));
  endtask

  task automatic try_write(input logic [7:0] d, input int d_ctl, input string tag);
    bit acc;
    acc = wp_unlock && !sleep_lock && !lowspd_on && !flash_pe && legal(d[2:0]);
    ctl_delay = d_ctl;
    if (acc) exp_mode = d[2:0];
    wr_cycle(RA, d);
    chk({tag, " mode"}, mode_out, exp_mode);
    chk({tag, " busy"}, busy_out, acc);
    chk({tag, " request"}, pc_req, acc);
    if (acc) begin
      @(negedge clk);
      chk("R10 read while busy", bus_rdata, rd_word(exp_mode, 1'b1));
      busy_window(d_ctl - 1);
    end else begin
      @(negedge clk);
      chk({tag, " read unchanged"}, bus_rdata, rd_word(exp_mode, 1'b0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset mode", mode_out, 3'b010);
    chk("R1 reset busy", busy_out, 0);
    chk("R1 reset request", pc_req, 0);
    chk("R1 reset read", bus_rdata, 8'h02);

    // R6 protection off
    try_write(8'h00, 2, "R6 protect");
    wp_unlock = 1'b1;
    // R3 accepted, reserved bits set (R10 ignores them)
    try_write(8'hF8, 3, "R3 write high");
    try_write(8'hEA, 1, "R10 reserved bits");
    // R2 prohibited codes
    for (int c = 0; c < 8; c++) begin
      if (!legal(3'(c))) try_write(8'(c), 1, "R2 prohibited");
    end
    sleep_lock = 1'b1; try_write(8'h00, 2, "R7 sleep"); sleep_lock = 1'b0;
    lowspd_on  = 1'b1; try_write(8'h00, 2, "R8 lowspd"); lowspd_on  = 1'b0;
    flash_pe   = 1'b1; try_write(8'h00, 2, "R9 flash"); flash_pe   = 1'b0;

    // R10 wrong address: write ignored, read zero
    wr_cycle(8'h33, 8'h00);
    chk("R10 miss write ignored", mode_out, exp_mode);
    chk("R10 miss no request", pc_req, 0);
    bus_addr = 8'h33;
    @(negedge clk);
    chk("R10 miss read zero", bus_rdata, 0);
    bus_addr = RA;
    @(negedge clk);

    // constrained random
    void'($urandom(32'h5eed));
    for (int n = 0; n < 300; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      case ($urandom_range(0, 3))
        0: d[2:0] = 3'b000;
        1: d[2:0] = 3'b010;
        default: ;
      endcase
      wp_unlock  = ($urandom_range(0, 7) != 0);
      sleep_lock = ($urandom_range(0, 5) == 0);
      lowspd_on  = ($urandom_range(0, 5) == 0);
      flash_pe   = ($urandom_range(0, 5) == 0);
      try_write(d, $urandom_range(1, 6), "R3 random");
      wp_unlock = 1'b1; sleep_lock = 1'b0; lowspd_on = 1'b0; flash_pe = 1'b0;
    end
    summary();
  end
endmodule